// File: doc/BRIEF.md
# Trigger Line Driver with Interval Timer

This block drives ten trigger outputs: eight TTL-class lines (bits 7:0) and two ECL-class lines (bits 9:8). Software controls them with 16-bit command words. Each command carries a line-select mask and an action. The action can latch the selected lines high, release them, or fire a fixed-length pulse on them. The electrical drivers sit outside the block and are not part of it.

A built-in interval timer counts a 10 MHz tick enable, so each step is 100 ns. Each time the timer expires, it pulses a programmable set of lines. The timer is reached indirectly. A 4-bit select register chooses which internal register the shared data port writes: the low half of the 32-bit interval, the high half, or the timer control word. Each output is the OR of its latched level, its command pulse and its timer pulse, and is registered once before leaving the block.

Top module: `trig_drv`

## Requirements
- R1: Reset (synchronous, active high) drives all outputs to 0, clears the latched levels and the pulses, and stops the timer.
- R2: A command word with bits 15:14 = 00 latches high every line whose bit in word[9:0] is 1. The line stays high until a release command or a reset.
- R3: Bits 15:14 = 01 releases the latched level of every selected line.
- R4: Bits 15:14 = 10 pulses the selected lines for exactly 15 ticks. Pulsing a line whose pulse is still running restarts the 15-tick count.
- R5: Bits 15:14 = 11 has no effect. Lines whose select bit is 0 are never changed by a command.
- R6: The indirect data port writes the interval bits 15:0 when the select code is 0000, the interval bits 31:16 when it is 0001, and timer control when it is 1000. Every other select code is ignored.
- R7: Timer control bit 15 = 1 runs the timer and bits 9:0 choose the lines it drives. With an interval of N steps, the timer expires every N ticks, counted from the start. At each expiry the chosen lines are pulsed for 15 ticks.
- R8: An interval below 20 steps is treated as 20.
- R9: An interval written while the timer runs leaves the current period unchanged and takes effect from the next period.
- R10: Each output is the OR of its latched level, its command pulse and its timer pulse, so releasing a line during a timer pulse keeps it high until the pulse ends. Outputs update one clock after the internal state changes.
- R11: Writing control bit 15 = 0 stops the timer, and no further expiries occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 10 MHz step enable, one clock wide |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Action in bits 15:14, line mask in bits 9:0 |
| sel_we | input | 1 | Select register write strobe |
| sel_code | input | 4 | Indirect register select value |
| ind_we | input | 1 | Indirect data write strobe |
| ind_word | input | 16 | Indirect data |
| trig_out | output | 10 | Trigger outputs, TTL in 7:0, ECL in 9:8 |

## Verification
A timer expiry and a command can act on the same line together. The line's latched level, its command pulse and its timer pulse then overlap, and the output must be their union. The bench provokes this in two ways. First, it latches a line just before an expiry and then releases it while the timer pulse is running; the line must stay high for the rest of the pulse and drop only on the 15th tick. Second, it fires a command pulse on a line that is already latched; the line must not drop when the pulse ends. A second overlap is an interval reload that arrives in the middle of a running period. The bench judges it by counting ticks to the next two expiries: the first must keep the old spacing and the second must use the new one.

// File: rtl/trg_pkg.sv
package trg_pkg;
  typedef enum logic [1:0] {
    ACT_SET   = 2'b00,
    ACT_CLR   = 2'b01,
    ACT_PULSE = 2'b10,
    ACT_NONE  = 2'b11
  } trg_act_e;

  localparam int ACT_HI  = 15;
  localparam int ACT_LO  = 14;
  localparam int RUN_BIT = 15;

  localparam logic [3:0] SEL_LO   = 4'b0000;
  localparam logic [3:0] SEL_HI   = 4'b0001;
  localparam logic [3:0] SEL_CTRL = 4'b1000;
endpackage

// File: rtl/trg_static.sv
module trg_static #(
  parameter int NL = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [15:0]   word,
  output logic [NL-1:0] lvl
);
  import trg_pkg::*;

  trg_act_e       act;
  logic [NL-1:0]  sel;

  assign act = trg_act_e'(word[ACT_HI:ACT_LO]);
  assign sel = word[NL-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
    end else if (we) begin
      case (act)
        ACT_SET: lvl <= lvl | sel;
        ACT_CLR: lvl <= lvl & ~sel;
        default: lvl <= lvl;
      endcase
    end
  end
endmodule

// File: rtl/trg_pulse_bank.sv
module trg_pulse_bank #(
  parameter int NL          = 10,
  parameter int PULSE_TICKS = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [NL-1:0] fire,
  output logic [NL-1:0] act
);
  localparam int CW = $clog2(PULSE_TICKS + 1);

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (fire[g]) begin
        cnt <= CW'(PULSE_TICKS);
      end else if (tick && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
    assign act[g] = (cnt != '0);
  end
endmodule

// File: rtl/trg_interval.sv
module trg_interval #(
  parameter int TMR_W      = 32,
  parameter int MIN_PERIOD = 20,
  parameter int NL         = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [3:0]       sel,
  input  logic             ind_we,
  input  logic [15:0]      ind_word,
  output logic             expire,
  output logic             run,
  output logic [NL-1:0]    mask,
  output logic [TMR_W-1:0] period
);
  import trg_pkg::*;

  localparam int HI_W = TMR_W - 16;

  logic [15:0]      load_lo;
  logic [HI_W-1:0]  load_hi;
  logic [TMR_W-1:0] raw;
  logic [TMR_W-1:0] cnt;
  logic             ctrl_wr;
  logic             start;

  assign raw     = {load_hi, load_lo};
  assign period  = (raw < TMR_W'(MIN_PERIOD)) ? TMR_W'(MIN_PERIOD) : raw;
  assign ctrl_wr = ind_we && (sel == SEL_CTRL);
  assign start   = ctrl_wr && ind_word[RUN_BIT] && !run;
  assign expire  = run && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_lo <= '0;
      load_hi <= '0;
      run     <= 1'b0;
      mask    <= '0;
      cnt     <= '0;
    end else begin
      if (ind_we && sel == SEL_LO) load_lo <= ind_word;
      if (ind_we && sel == SEL_HI) load_hi <= ind_word[HI_W-1:0];
      if (ctrl_wr) begin
        run  <= ind_word[RUN_BIT];
        mask <= ind_word[NL-1:0];
      end
      if (start) begin
        cnt <= period - 1'b1;
      end else if (run && tick) begin
        cnt <= (cnt == '0) ? period - 1'b1 : cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_drv.sv
module trig_drv #(
  parameter int N_TTL       = 8,
  parameter int N_ECL       = 2,
  parameter int PULSE_TICKS = 15,
  parameter int TMR_W       = 32,
  parameter int MIN_PERIOD  = 20,
  localparam int NL         = N_TTL + N_ECL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmd_we,
  input  logic [15:0]   cmd_word,
  input  logic          sel_we,
  input  logic [3:0]    sel_code,
  input  logic          ind_we,
  input  logic [15:0]   ind_word,
  output logic [NL-1:0] trig_out
);
  import trg_pkg::*;

  logic [3:0]       sel_q;
  logic [NL-1:0]    lvl_q;
  logic [NL-1:0]    cmd_fire;
  logic [NL-1:0]    cmd_act;
  logic [NL-1:0]    tmr_fire;
  logic [NL-1:0]    tmr_act;
  logic             tmr_expire;
  logic             tmr_run;
  logic [NL-1:0]    tmr_mask;
  logic [TMR_W-1:0] tmr_period;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_we) sel_q <= sel_code;
  end

  assign cmd_fire = (cmd_we && trg_act_e'(cmd_word[ACT_HI:ACT_LO]) == ACT_PULSE)
                    ? cmd_word[NL-1:0] : '0;
  assign tmr_fire = tmr_expire ? tmr_mask : '0;

  trg_static #(.NL(NL)) u_static (
    .clk(clk), .rst(rst), .we(cmd_we), .word(cmd_word), .lvl(lvl_q)
  );

  trg_pulse_bank #(.NL(NL), .PULSE_TICKS(PULSE_TICKS)) u_cmd_pulse (
    .clk(clk), .rst(rst), .tick(tick), .fire(cmd_fire), .act(cmd_act)
  );

  trg_pulse_bank #(.NL(NL), .PULSE_TICKS(PULSE_TICKS)) u_tmr_pulse (
    .clk(clk), .rst(rst), .tick(tick), .fire(tmr_fire), .act(tmr_act)
  );

  trg_interval #(.TMR_W(TMR_W), .MIN_PERIOD(MIN_PERIOD), .NL(NL)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .sel(sel_q),
    .ind_we(ind_we), .ind_word(ind_word),
    .expire(tmr_expire), .run(tmr_run), .mask(tmr_mask), .period(tmr_period)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_out <= '0;
    else     trig_out <= lvl_q | cmd_act | tmr_act;
  end
endmodule

// File: rtl/trig_drv_chk.sv
module trig_drv_chk #(
  parameter int NL         = 10,
  parameter int TMR_W      = 32,
  parameter int MIN_PERIOD = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             cmd_we,
  input logic [15:0]      cmd_word,
  input logic             ind_we,
  input logic [3:0]       sel_q,
  input logic [NL-1:0]    lvl_q,
  input logic [NL-1:0]    tmr_act,
  input logic             tmr_expire,
  input logic             tmr_run,
  input logic [NL-1:0]    tmr_mask,
  input logic [TMR_W-1:0] tmr_period,
  input logic [NL-1:0]    trig_out
);
  logic        run_d;
  logic [31:0] gap;
  logic        started;

  assign started = tmr_run && !run_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d <= 1'b0;
      gap   <= '0;
    end else begin
      run_d <= tmr_run;
      if (tmr_expire)               gap <= '0;
      else if (started)             gap <= tick ? 32'd1 : 32'd0;
      else if (tmr_run && tick)     gap <= gap + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> trig_out == '0);

  a_r2_set_latches: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_word[15:14] == 2'b00) |=>
      ((lvl_q & $past(cmd_word[NL-1:0])) == $past(cmd_word[NL-1:0])));

  a_r3_clr_releases: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_word[15:14] == 2'b01) |=>
      ((lvl_q & $past(cmd_word[NL-1:0])) == '0));

  a_r5_none_keeps: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_word[15:14] == 2'b11) |=> $stable(lvl_q));

  a_r6_reserved_sel: assert property (@(posedge clk) disable iff (rst)
    (ind_we && sel_q != 4'b0000 && sel_q != 4'b0001 && sel_q != 4'b1000) |=>
      ($stable(tmr_period) && $stable(tmr_mask) && $stable(tmr_run)));

  a_r7_expiry_pulses: assert property (@(posedge clk) disable iff (rst)
    tmr_expire |=> ((tmr_act & $past(tmr_mask)) == $past(tmr_mask)));

  a_r8_min_spacing: assert property (@(posedge clk) disable iff (rst)
    tmr_expire |-> (gap >= 32'(MIN_PERIOD - 1)));

  a_r11_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    !tmr_run |-> !tmr_expire);
endmodule

bind trig_drv trig_drv_chk #(.NL(NL), .TMR_W(TMR_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cmd_we(cmd_we), .cmd_word(cmd_word),
  .ind_we(ind_we), .sel_q(sel_q), .lvl_q(lvl_q), .tmr_act(tmr_act),
  .tmr_expire(tmr_expire), .tmr_run(tmr_run), .tmr_mask(tmr_mask),
  .tmr_period(tmr_period), .trig_out(trig_out)
);

// File: tb/sim_trig_drv.sv
module sim_trig_drv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        sel_we = 1'b0;
  logic [3:0]  sel_code = '0;
  logic        ind_we = 1'b0;
  logic [15:0] ind_word = '0;
  logic [9:0]  trig_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  trig_drv u0 (
    .clk(clk), .rst(rst), .tick(tick), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .sel_we(sel_we), .sel_code(sel_code), .ind_we(ind_we), .ind_word(ind_word),
    .trig_out(trig_out)
  );

  // monitor: pops expectations and compares them at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (trig_out !== e) begin
        n_bad++;
        $display("FAIL %s: trig_out=%03h expected=%03h", t, trig_out, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [9:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0; cyc();
    end
  endtask

  task automatic cmd(input logic [1:0] act, input logic [9:0] m);
    cmd_word = {act, 4'b0000, m};
    cmd_we = 1'b1; cyc(); cmd_we = 1'b0; cyc();
  endtask

  task automatic ind(input logic [3:0] s, input logic [15:0] d);
    sel_code = s; sel_we = 1'b1; cyc(); sel_we = 1'b0;
    ind_word = d; ind_we = 1'b1; cyc(); ind_we = 1'b0; cyc();
  endtask

  initial begin
    cyc(); cyc();
    rst = 1'b0; cyc();
    expect_out(10'h000, "R1 reset state");

    cmd(2'b00, 10'h205);
    expect_out(10'h205, "R2 set TTL and ECL lines");
    ticks(20);
    expect_out(10'h205, "R2 level holds over ticks");

    cmd(2'b01, 10'h004);
    expect_out(10'h201, "R3 release one line");

    cmd(2'b11, 10'h3FF);
    expect_out(10'h201, "R5 reserved action ignored");

    cmd(2'b10, 10'h0F0);
    expect_out(10'h2F1, "R4 pulse starts");
    ticks(14);
    expect_out(10'h2F1, "R4 pulse alive at 14 ticks");
    ticks(1);
    expect_out(10'h201, "R4 pulse ends at 15 ticks");

    cmd(2'b10, 10'h001);
    ticks(15);
    expect_out(10'h201, "R10 latched line survives its pulse end");

    cmd(2'b10, 10'h010);
    ticks(10);
    cmd(2'b10, 10'h010);
    ticks(14);
    expect_out(10'h211, "R4 retrigger restarts count");
    ticks(1);
    expect_out(10'h201, "R4 retriggered pulse ends");

    cmd(2'b01, 10'h3FF);
    expect_out(10'h000, "R3 release all");

    // timer, interval 50
    ind(4'b0000, 16'd50);
    ind(4'b0001, 16'd0);
    ind(4'b1000, 16'h8003);
    ticks(49);
    expect_out(10'h000, "R7 no expiry before 50 ticks");
    ticks(1);
    expect_out(10'h003, "R7 expiry at 50 ticks");
    ticks(14);
    expect_out(10'h003, "R7 timer pulse alive");
    ticks(1);
    expect_out(10'h000, "R7 timer pulse ends");
    ticks(34);
    expect_out(10'h000, "R7 quiet before second expiry");
    ticks(1);
    expect_out(10'h003, "R7 second expiry at 50");
    ticks(15);

    // reload mid-period
    ind(4'b0000, 16'd30);
    ticks(34);
    expect_out(10'h000, "R9 old period still running");
    ticks(1);
    expect_out(10'h003, "R9 old period completes at 50");
    ticks(15);
    ticks(14);
    expect_out(10'h000, "R9 before new period end");
    ticks(1);
    expect_out(10'h003, "R9 new period of 30");
    ticks(15);

    // reserved select codes
    ind(4'b0101, 16'hFFFF);
    ind(4'b0010, 16'h0005);
    ticks(14);
    expect_out(10'h000, "R6 reserved select ignored, before expiry");
    ticks(1);
    expect_out(10'h003, "R6 period still 30");
    ticks(15);

    // overlap of latched level and timer pulse
    ticks(14);
    cmd(2'b00, 10'h001);
    expect_out(10'h001, "R10 latch before expiry");
    ticks(1);
    expect_out(10'h003, "R10 expiry with latched line");
    cmd(2'b01, 10'h003);
    expect_out(10'h003, "R10 release during timer pulse");
    ticks(14);
    expect_out(10'h003, "R10 timer pulse keeps line");
    ticks(1);
    expect_out(10'h000, "R10 line drops at pulse end");

    // stop
    ind(4'b1000, 16'h0003);
    ticks(40);
    expect_out(10'h000, "R11 no expiry after stop");

    // clamp
    ind(4'b0000, 16'd5);
    ind(4'b1000, 16'h8300);
    ticks(19);
    expect_out(10'h000, "R8 no expiry before 20");
    ticks(1);
    expect_out(10'h300, "R8 clamped to 20");
    ticks(15);
    ticks(4);
    expect_out(10'h000, "R8 quiet before next");
    ticks(1);
    expect_out(10'h300, "R8 second clamped expiry");

    // reset mid-activity
    cmd(2'b00, 10'h0FF);
    rst = 1'b1; cyc(); rst = 1'b0; cyc();
    expect_out(10'h000, "R1 reset clears outputs");
    ticks(25);
    expect_out(10'h000, "R1 timer stopped by reset");

    cyc(); cyc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule